// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes a serial line that has already been brought into the local clock domain and turns it into 8-bit characters. A strobe at eight times the bit rate paces all timing. A falling edge on the idle-high line starts a frame. The start bit is confirmed at its midpoint, and each later bit is sampled at the centre of its period. Data arrives least significant bit first. Parity checking can be switched on, with a choice of even or odd sense.

When the last data bit has been sampled, the character moves from the shift register into a holding register. The host can only read the holding register, and a single interrupt tells the host a character is waiting. Error flags cover parity, stop-bit and overrun faults. A read strobe empties the holding register and clears every flag at once.

The raw line and a recovered bit clock are also driven on two outputs. A downstream checksum or CRC unit can then consume the same stream.

Top module: `serial_rx_unit`

## Requirements
- R1: With `par_en` low a frame is start + 8 data + stop (10 bit times). With `par_en` high a parity bit sits between the last data bit and the stop bit (11 bit times).
- R2: Data bits are taken least significant bit first, one per 8 ticks, each sampled 4 ticks into its bit. At the tick that samples the eighth data bit, the character appears on `rd_data` and `full_flag` and `irq` go high.
- R3: If the line is high again at the mid-start sample (4 ticks after the falling edge), the receiver returns to idle and receives nothing.
- R4: With `par_en` high, `par_err` is set when the received parity bit differs from the expected one. The expected bit is the XOR of the 8 data bits for `par_odd`=0 (even), and its inverse for `par_odd`=1 (odd).
- R5: A low level at the stop-bit sample sets `frm_err`.
- R6: If a character completes while `full_flag` is already set and no read occurs in that cycle, `ovr_err` is set and `rd_data` keeps the older character.
- R7: `full_flag`, and `irq` which equals it, stay high until `rd_stb` is pulsed. A one-cycle `rd_stb` clears `full_flag`, `par_err`, `frm_err` and `ovr_err` together. A flag being set in the same cycle takes priority over the clear.
- R8: `fwd_data` always equals `rx_in`. `fwd_clk` rises exactly at each of the 8 data-bit samples of a frame and falls 4 ticks later.
- R9: A synchronous active-low `rst_n` returns the receiver to idle with all flags, `irq` and `fwd_clk` low.
- R10: With `par_en` low, no parity bit is expected and `par_err` is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Enable pulse at 8x the bit rate |
| rx_in | input | 1 | Synchronized serial line, idle high |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_stb | input | 1 | One-cycle read of the holding register |
| rd_data | output | 8 | Holding register contents |
| full_flag | output | 1 | A character is waiting |
| irq | output | 1 | Interrupt, equal to the full status |
| par_err | output | 1 | Parity mismatch seen |
| frm_err | output | 1 | Stop bit sampled low |
| ovr_err | output | 1 | Character lost because the holding register was full |
| fwd_data | output | 1 | Serial line forwarded for chaining |
| fwd_clk | output | 1 | Recovered bit clock forwarded for chaining |

## Verification
A bit counter or tick phase that has slipped shows up at the ports by the end of the frame. The byte on `rd_data` is then shifted or corrupted, a stop or parity bit is taken from the wrong slot and raises a spurious `frm_err` or `par_err`, and `fwd_clk` shows the wrong number of rising edges. A state machine that fails to drop a glitched start leaves `full_flag` set one frame time later. A lost full status appears either as a missing interrupt or as `ovr_err` failing to rise on the next character.

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
  parameter int DW  = 8,
  parameter int OSR = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_in,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rd_stb,
  output logic [DW-1:0] rd_data,
  output logic          full_flag,
  output logic          irq,
  output logic          par_err,
  output logic          frm_err,
  output logic          ovr_err,
  output logic          fwd_data,
  output logic          fwd_clk
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] TOP  = BW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bitn;
  logic [DW-1:0]  shreg, hold;
  logic           full, perr, ferr, oerr, fclk;

  wire [DW-1:0] word   = {rx_in, shreg[DW-1:1]};
  wire          sample = tick && (cnt == LAST);
  wire          land   = (st == S_DATA) && sample && (bitn == TOP);
  wire          exp_p  = (^shreg) ^ par_odd;

  assign rd_data   = hold;
  assign full_flag = full;
  assign irq       = full;
  assign par_err   = perr;
  assign frm_err   = ferr;
  assign ovr_err   = oerr;
  assign fwd_data  = rx_in;
  assign fwd_clk   = fclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      fclk  <= 1'b0;
    end else begin
      if (st == S_IDLE) fclk <= 1'b0;
      else if (tick && cnt == MID) fclk <= 1'b0;
      case (st)
        S_IDLE:
          if (tick && !rx_in) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (tick) begin
            if (cnt == MID) begin
              cnt <= '0;
              st  <= rx_in ? S_IDLE : S_DATA;
              bitn <= '0;
            end else cnt <= cnt + 1'b1;
          end
        S_DATA:
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (sample) begin
              shreg <= word;
              fclk  <= 1'b1;
              bitn  <= bitn + 1'b1;
              if (bitn == TOP) st <= par_en ? S_PAR : S_STOP;
            end
          end
        S_PAR:
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (sample) st <= S_STOP;
          end
        S_STOP:
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (sample) st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      oerr <= 1'b0;
    end else begin
      if (rd_stb) begin
        full <= 1'b0;
        perr <= 1'b0;
        ferr <= 1'b0;
        oerr <= 1'b0;
      end
      if (land) begin
        full <= 1'b1;
        if (full && !rd_stb) oerr <= 1'b1;
        else hold <= word;
      end
      if (st == S_PAR && sample && par_en && (rx_in != exp_p)) perr <= 1'b1;
      if (st == S_STOP && sample && !rx_in) ferr <= 1'b1;
    end
  end
endmodule

module serial_rx_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_in,
  input logic          par_en,
  input logic          rd_stb,
  input logic [DW-1:0] rd_data,
  input logic          full_flag,
  input logic          irq,
  input logic          par_err,
  input logic          frm_err,
  input logic          ovr_err,
  input logic          fwd_clk
);
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag && !rd_stb |=> full_flag);
  a_r6_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag && !rd_stb |=> $stable(rd_data));
  a_r5_ferr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> $past(!rx_in));
  a_r10_perr_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> $past(par_en));
  a_r6_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(full_flag));
  a_r8_land_on_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_flag) |-> $rose(fwd_clk));
  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !full_flag && !irq && !ovr_err && !par_err && !frm_err && !fwd_clk);
endmodule

bind serial_rx_unit serial_rx_unit_chk #(.DW(DW)) chk_i (.*);

// File: tb/serial_rx_unit_tb.sv
module serial_rx_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b0, rx_in = 1'b1, par_en = 1'b0, par_odd = 1'b0, rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic full_flag, irq, par_err, frm_err, ovr_err, fwd_data, fwd_clk;

  int n_run = 0, n_fail = 0;
  int edges = 0, mism = 0;
  logic prev_fc = 1'b0;

  always #10 clk = ~clk;

  serial_rx_unit dut_i (.clk, .rst_n, .tick, .rx_in, .par_en, .par_odd, .rd_stb,
    .rd_data, .full_flag, .irq, .par_err, .frm_err, .ovr_err, .fwd_data, .fwd_clk);

  always @(negedge clk) begin
    if (fwd_clk && !prev_fc) edges++;
    prev_fc = fwd_clk;
    if (fwd_data !== rx_in) mism++;
  end

  // [13:6] data, [5] par_en, [4] par_odd, [3] flip parity, [2] stop level, [1] exp par_err, [0] exp frm_err
  localparam logic [13:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h7E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h96, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_ticks(input logic v, input int n);
    for (int i = 0; i < n; i++)
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        rx_in = v;
        tick = (c == 0);
      end
  endtask

  task automatic send(input logic [7:0] d, input logic pen, input logic podd,
                      input logic flip, input logic stop);
    par_en = pen;
    par_odd = podd;
    do_ticks(1'b0, 8);
    for (int b = 0; b < 8; b++) do_ticks(d[b], 8);
    if (pen) do_ticks((^d) ^ podd ^ flip, 8);
    do_ticks(stop, 8);
    do_ticks(1'b1, 16);
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 full after reset", full_flag, 0);
    chk("R9 irq after reset", irq, 0);
    chk("R9 errs after reset", {par_err, frm_err, ovr_err}, 0);
    chk("R9 fwd_clk after reset", fwd_clk, 0);
    do_ticks(1'b1, 8);

    for (int k = 0; k < 8; k++) begin
      int e0;
      e0 = edges;
      send(VEC[k][13:6], VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2]);
      chk("R2 data", rd_data, VEC[k][13:6]);
      chk("R7 full set", full_flag, 1);
      chk("R7 irq set", irq, 1);
      chk("R4/R10 par_err", par_err, VEC[k][1]);
      chk("R1/R5 frm_err", frm_err, VEC[k][0]);
      chk("R6 no ovr", ovr_err, 0);
      chk("R8 fwd_clk edges", edges - e0, 8);
      rd_pulse();
      chk("R7 cleared by read", {full_flag, irq, par_err, frm_err, ovr_err}, 0);
    end
    chk("R8 fwd_data mirrors rx", mism, 0);

    par_en = 1'b0;
    do_ticks(1'b0, 2);
    do_ticks(1'b1, 90);
    chk("R3 glitch ignored", full_flag, 0);

    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
    do_ticks(1'b1, 40);
    chk("R7 full held without read", full_flag, 1);
    chk("R7 irq held without read", irq, 1);
    send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 ovr set", ovr_err, 1);
    chk("R6 old data kept", rd_data, 8'h5A);
    rd_pulse();
    chk("R7 read clears ovr", {full_flag, ovr_err}, 0);

    send(8'h11, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 mid-run reset", {full_flag, irq, par_err, frm_err, ovr_err, fwd_clk}, 0);
    send(8'h42, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9 receive after reset", rd_data, 8'h42);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule